// File: doc/BRIEF.md
# Serial Hold Pause Controller

This block sits at the pin side of a byte-oriented serial slave (clock-phase 0 and clock-phase 3 style: input sampled on the rising clock edge, output shifted on the falling edge). It lets the bus master pause a transfer through an active-low pause input without deselecting the slave. While paused, the block freezes the bit counter and both shift registers, ignores the serial clock and data input, and turns off the serial output driver. When the pause ends, the transfer continues from the same bit.

The pause takes effect only while the serial clock is low. A pause request or release made during the clock high phase is held back until the clock falls. If the pause input returns to its previous level before that fall, the request is dropped. A high chip select always wins: it clears the pause, resets the bit position and reloads the transmit byte. All pins are sampled by the system clock and are assumed to be synchronized already.

Top module: `serialHoldGate`

## Requirements
- R1: While reset is asserted and after its release with chip select high: heldFlag = 0, soOe = 0, bitPos = 0, rxValid = 0.
- R2: When csN is high, soOe is 0 at once, and one clock later heldFlag = 0 and bitPos = 0, whatever the state of holdN and whether or not a pause was in progress.
- R3: With csN low and sck low, a low on holdN sets heldFlag on the next clock edge.
- R4: With csN low and sck high, a low on holdN leaves heldFlag at 0 until sck is sampled low. heldFlag then sets on the following clock edge. The sck falling edge that starts the pause still shifts the output.
- R5: Release follows the same rule. With sck low, a high on holdN clears heldFlag on the next clock edge. With sck high, heldFlag stays set until sck is sampled low, and that falling edge does not shift the output.
- R6: If holdN goes low and returns high while sck stays high, heldFlag never sets.
- R7: While heldFlag is 1, sck edges and si have no effect: bitPos and the received bits are unchanged, and after release the next rising edge samples the bit that comes after the last one sampled before the pause.
- R8: soOe = 1 exactly when csN is low and heldFlag is 0.
- R9: si is sampled on each counted sck rising edge, MSB first. bitPos counts 0 to DATA_W-1 and wraps. After the DATA_W-th counted rise, rxByte holds the assembled byte and rxValid is high for one clock.
- R10: txData is loaded while csN is high and on a counted falling edge when bitPos = 0. soData shows its MSB first and moves to the next lower bit on each other counted sck falling edge.
- R11: While csN is high, holdN has no effect: heldFlag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock level |
| holdN | input | 1 | Active-low pause request |
| si | input | 1 | Serial data in |
| txData | input | DATA_W | Byte to transmit, captured at the load points |
| soData | output | 1 | Serial data out value |
| soOe | output | 1 | Output driver enable; 0 means high impedance |
| heldFlag | output | 1 | High while the transfer is paused |
| bitPos | output | CNT_W | Bit position inside the current byte |
| rxByte | output | DATA_W | Last complete received byte |
| rxValid | output | 1 | One-clock pulse when rxByte updates |

## Verification
heldFlag, bitPos, rxByte and soData are registered. Each one changes on the first system clock edge after the pin level that triggers it is sampled. soOe follows csN in the same cycle and follows heldFlag one edge later. The bench drives pins on the falling system clock edge and samples after two rising edges. By then one edge has acted on the change and a second edge has confirmed that the state holds, because sck has not moved in between. The table separates every sck edge into its own vector, so whether each edge is counted or ignored shows up directly in bitPos and soData.

// File: rtl/serialHoldPkg.sv
`timescale 1ns/1ps
package serialHoldPkg;

  // Strobes from the pause control to the serial datapath
  typedef struct packed {
    logic clear;   // deselected: reset position, reload transmit byte
    logic sample;  // counted rising edge: take si
    logic shift;   // counted falling edge: advance output
    logic held;    // transfer paused
  } serStrobe_t;

endpackage

// File: rtl/holdCtrl.sv
`timescale 1ns/1ps
module holdCtrl
  import serialHoldPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sck,
  input  logic       holdN,
  output serStrobe_t strb
);

  logic sckQ;
  logic held;
  logic heldNext;
  logic sckRise;
  logic sckFall;

  assign sckRise = sck & ~sckQ;
  assign sckFall = ~sck & sckQ;

  // The pause level only follows the request while sck is low, so a
  // request made in the high phase waits for the fall and is dropped
  // if it is withdrawn before then.
  always_comb begin
    if (csN)       heldNext = 1'b0;
    else if (!sck) heldNext = ~holdN;
    else           heldNext = held;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckQ <= 1'b0;
      held <= 1'b0;
    end else begin
      sckQ <= sck;
      held <= heldNext;
    end
  end

  // Edges count only when the pause register is clear in that cycle.
  // The fall that starts a pause is counted; the fall that ends it is not.
  always_comb begin
    strb.clear  = csN;
    strb.sample = ~csN & ~held & sckRise;
    strb.shift  = ~csN & ~held & sckFall;
    strb.held   = held;
  end

  // R2
  cs_clears_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> !held);

  // R4
  hold_waits_sck_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sck) |=> $stable(held));

  // R7
  strobe_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.sample, strb.shift, strb.clear}));

endmodule

// File: rtl/serialDp.sv
`timescale 1ns/1ps
module serialDp
  import serialHoldPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  serStrobe_t        strb,
  input  logic              si,
  input  logic [DATA_W-1:0] txData,
  output logic              soData,
  output logic [CNT_W-1:0]  bitPos,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);

  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxShift[DATA_W-2:0], si};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt  <= '0;
      rxShift <= '0;
      txShift <= '0;
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= 1'b0;
      if (strb.clear) begin
        bitCnt  <= '0;
        txShift <= txData;
      end else if (strb.sample) begin
        rxShift <= rxNext;
        if (bitCnt == LAST_POS) begin
          bitCnt  <= '0;
          rxByte  <= rxNext;
          rxValid <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end else if (strb.shift) begin
        if (bitCnt == '0) txShift <= txData;
        else              txShift <= {txShift[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign soData = txShift[DATA_W-1];
  assign bitPos = bitCnt;

  // R7
  held_freezes_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.held && !strb.clear) |=> ($stable(bitCnt) && $stable(rxShift) && $stable(txShift)));

  // R9
  byte_done_at_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (bitCnt == '0));

  // R2
  clear_zeroes_pos_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (bitCnt == '0));

endmodule

// File: rtl/serialHoldGate.sv
`timescale 1ns/1ps
module serialHoldGate
  import serialHoldPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              holdN,
  input  logic              si,
  input  logic [DATA_W-1:0] txData,
  output logic              soData,
  output logic              soOe,
  output logic              heldFlag,
  output logic [CNT_W-1:0]  bitPos,
  output logic [DATA_W-1:0] rxByte,
  output logic              rxValid
);

  serStrobe_t strb;

  holdCtrl i_holdCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .csN   (csN),
    .sck   (sck),
    .holdN (holdN),
    .strb  (strb)
  );

  serialDp #(.DATA_W(DATA_W)) i_serialDp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .si      (si),
    .txData  (txData),
    .soData  (soData),
    .bitPos  (bitPos),
    .rxByte  (rxByte),
    .rxValid (rxValid)
  );

  assign heldFlag = strb.held;
  assign soOe     = ~csN & ~strb.held;

  // R11
  no_hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN)) |-> !heldFlag);

endmodule

// File: tb/test_serialHoldGate.sv
`timescale 1ns/1ps
module test_serialHoldGate;

  localparam int DATA_W = 8;
  localparam int CNT_W  = 3;
  localparam logic [DATA_W-1:0] TX_BYTE = 8'hC3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sck = 1'b0, holdN = 1'b1, si = 1'b0;
  logic [DATA_W-1:0] txData = TX_BYTE;
  logic soData, soOe, heldFlag, rxValid;
  logic [CNT_W-1:0] bitPos;
  logic [DATA_W-1:0] rxByte;

  int nChecks = 0;
  int nFails  = 0;
  int rxPulses = 0;
  bit countPulses = 1'b0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  serialHoldGate #(.DATA_W(DATA_W)) i_serialHoldGate (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .holdN(holdN), .si(si),
    .txData(txData), .soData(soData), .soOe(soOe), .heldFlag(heldFlag),
    .bitPos(bitPos), .rxByte(rxByte), .rxValid(rxValid)
  );

  // fields: csN sck holdN si | held oe so | pos[2:0]
  localparam int NVEC = 30;
  localparam logic [9:0] VEC [NVEC] = '{
    10'b1010_001_000, // 0  deselected, tx byte loaded           R10
    10'b0010_011_000, // 1  select                               R8
    10'b0111_011_001, // 2  rise samples 1                       R9
    10'b0011_011_001, // 3  fall -> bit6
    10'b0110_011_010, // 4  rise samples 0
    10'b0010_010_010, // 5  fall -> bit5
    10'b0000_100_010, // 6  pause with sck low                   R3
    10'b0101_100_010, // 7  rise ignored while paused            R7
    10'b0001_100_010, // 8  fall ignored
    10'b0011_010_010, // 9  release with sck low                 R5
    10'b0111_010_011, // 10 rise samples 1, resumes              R7
    10'b0101_010_011, // 11 pause requested in high phase        R4
    10'b0001_100_011, // 12 takes effect at fall, fall counted   R4
    10'b0100_100_011, // 13 rise ignored
    10'b0110_100_011, // 14 release requested in high phase      R5
    10'b0010_010_011, // 15 release at fall, fall not counted    R5
    10'b0110_010_100, // 16 rise samples 0
    10'b0100_010_100, // 17 pause requested in high phase        R6
    10'b0110_010_100, // 18 withdrawn                            R6
    10'b0010_010_100, // 19 fall, no pause, -> bit3              R6
    10'b0111_010_101, // 20
    10'b0011_010_101, // 21 -> bit2
    10'b0110_010_110, // 22
    10'b0010_011_110, // 23 -> bit1
    10'b0111_011_111, // 24
    10'b0011_011_111, // 25 -> bit0
    10'b0110_011_000, // 26 eighth rise, byte done               R9
    10'b1010_001_000, // 27 deselect                             R2
    10'b1000_001_000, // 28 pause ignored when deselected        R11
    10'b1010_001_000  // 29
  };

  task automatic checkVal(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic s, input logic h, input logic d);
    @(negedge clk);
    csN = c; sck = s; holdN = h; si = d;
    @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) if (countPulses && rxValid) rxPulses++;

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    nFails++;
    $display("FAIL watchdog: actual=running expected=done");
    finish();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    checkVal("R1 held", heldFlag, 0);
    checkVal("R1 oe", soOe, 0);
    checkVal("R1 pos", bitPos, 0);
    checkVal("R1 valid", rxValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    checkVal("R1 held after release", heldFlag, 0);

    countPulses = 1'b1;
    for (int i = 0; i < NVEC; i++) begin
      logic [9:0] v;
      v = VEC[i];
      drive(v[9], v[8], v[7], v[6]);
      nChecks++;
      if (heldFlag !== v[5] || soOe !== v[4] || soData !== v[3] || bitPos !== v[2:0]) begin
        nFails++;
        $display("FAIL R3-set vector %0d (R4 R5 R6 R7 R8 R10): actual held=%0b oe=%0b so=%0b pos=%0d expected held=%0b oe=%0b so=%0b pos=%0d",
                 i, heldFlag, soOe, soData, bitPos, v[5], v[4], v[3], v[2:0]);
      end
    end
    countPulses = 1'b0;

    // R9: assembled byte and one valid pulse
    checkVal("R9 rxByte", rxByte, 8'hAA);
    checkVal("R9 pulses", rxPulses, 1);

    // R2: deselect aborts a pause in progress
    drive(1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 1'b1);
    checkVal("R9 pos after rise", bitPos, 1);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    checkVal("R3 held", heldFlag, 1);
    drive(1'b1, 1'b0, 1'b0, 1'b0);
    checkVal("R2 held cleared", heldFlag, 0);
    checkVal("R2 oe off", soOe, 0);
    checkVal("R2 pos reset", bitPos, 0);
    drive(1'b0, 1'b0, 1'b0, 1'b0);
    checkVal("R3 re-entry", heldFlag, 1);
    checkVal("R8 oe while held", soOe, 0);
    drive(1'b1, 1'b0, 1'b1, 1'b0);
    checkVal("R11 idle", heldFlag, 0);

    finish();
  end

endmodule